// File: doc/BRIEF.md
# Comparator Output Sample Filter

This block conditions the single-bit output of an analog comparator before the rest of the chip uses it. The raw comparator bit, an external sample strobe and a window gate all arrive with no timing relation to the bus clock. Each one goes through a two-flop synchroniser. The bus-clock logic then produces one registered result bit, `filt_out`.

A small set of static control fields selects how that result is formed:

- **Off:** the result is held.
- **Continuous:** the raw bit passes straight through.
- **Sampled:** the raw bit is sampled on a sample instant. A sample instant is either a tick from an internal divider that reloads every `cfg_period` bus clocks, or a rising edge of the external strobe. With a count of one, each sample is copied to the output. With a larger count, the output changes only after that many consecutive samples all disagree with it.
- **Windowed:** the raw bit is passed only while the window gate is high. An optional variant adds a resampling step on the internal divider tick.

Software picks the divider period and the consecutive-sample count to trade noise rejection against recognition latency. The divider period should be just longer than the expected noise burst. The count sets how unlikely a false transition is.

Top module: `cmpflt_top`

## Requirements
- R1: While `rst` is high, `filt_out` is 0, and it is still 0 on the first cycle after reset is released.
- R2: With `cfg_en`=0, `filt_out` holds its value whatever the other inputs do.
- R3: Continuous mode applies when `cfg_en`=1, `cfg_win_en`=0, and either `cfg_cnt`=0 or (`cfg_ext_sel`=0 and `cfg_period`=0). In this mode a change of `raw_in` appears on `filt_out` exactly 3 bus-clock edges later.
- R4: In the sampled modes, `filt_out` changes only at a sample instant. With `cfg_ext_sel`=0, sample instants come once every `cfg_period` bus clocks.
- R5: With `cfg_cnt`=1, every sample is copied to `filt_out`. With the internal divider, a change of `raw_in` reaches the output no later than `cfg_period`+2 edges after it.
- R6: With `cfg_cnt`>=2, the output takes the new value only after `cfg_cnt` consecutive samples show it. With the internal divider, the latency lies between (`cfg_cnt`-1)×`cfg_period`+3 and `cfg_cnt`×`cfg_period`+2 edges.
- R7: A sample equal to the current output restarts the run of disagreeing samples. A full `cfg_cnt` new run is then needed.
- R8: With `cfg_ext_sel`=1, samples are taken only at rising edges of `strobe_in`. Without such an edge a change of `raw_in` has no effect on `filt_out`.
- R9: Plain windowed mode applies when `cfg_win_en`=1 and either `cfg_period`=0 or `cfg_ext_sel`=1. While `window_in` is high, `filt_out` follows `raw_in` with a 3-edge latency. While `window_in` is low, `filt_out` holds.
- R10: Windowed-resampled mode applies when `cfg_win_en`=1, `cfg_ext_sel`=0 and `cfg_period` is between 1 and 255. The windowed value is resampled on the divider tick, and the latency is at most `cfg_period`+3 edges. While `window_in` is low, `filt_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Raw comparator bit, asynchronous |
| strobe_in | input | 1 | External sample strobe, asynchronous, rising edge used |
| window_in | input | 1 | Window gate, asynchronous, high passes |
| cfg_en | input | 1 | Block enable |
| cfg_win_en | input | 1 | Window gating enable |
| cfg_ext_sel | input | 1 | 1: sample on strobe edges, 0: internal divider |
| cfg_cnt | input | CNT_W | Consecutive-sample count |
| cfg_period | input | PER_W | Divider period in bus clocks |
| filt_out | output | 1 | Filtered comparator result |

## Verification
The run counter and the divider are the hidden state. A run counter that is not cleared shows up as an output that flips earlier than (`cfg_cnt`-1)×`cfg_period`+3 edges after a change, or after too few strobe edges once a noise sample has interrupted a run. A divider with the wrong reload value shows up within one period as a latency outside the R5/R6 bounds. A wrong hold path in the window or off modes shows up within three edges as an output that moves while it must stay put.

// File: rtl/cmpflt_pkg.sv
package cmpflt_pkg;
  typedef enum logic [2:0] {
    MODE_OFF        = 3'd0,
    MODE_CONT       = 3'd1,
    MODE_SAMP_NF    = 3'd2,
    MODE_SAMP_FILT  = 3'd3,
    MODE_WIN        = 3'd4,
    MODE_WIN_RESAMP = 3'd5
  } mode_e;
endpackage

// File: rtl/cmpflt_sync.sv
module cmpflt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmpflt_tick.sv
module cmpflt_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             ext_sel,
  input  logic [PER_W-1:0] period,
  input  logic             strobe_s,
  output logic             tick
);
  logic [PER_W-1:0] div_q;
  logic             strobe_d;
  logic             int_tick;
  logic             ext_tick;

  assign int_tick = (period != '0) && (div_q == period - PER_W'(1));
  assign ext_tick = strobe_s & ~strobe_d;
  assign tick     = ext_sel ? ext_tick : int_tick;

  always_ff @(posedge clk) begin
    if (rst || clear)  div_q <= '0;
    else if (int_tick) div_q <= '0;
    else               div_q <= div_q + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_d <= 1'b0;
    else     strobe_d <= strobe_s;
  end
endmodule

// File: rtl/cmpflt_core.sv
module cmpflt_core
  import cmpflt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  mode_e            mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic             raw_s,
  input  logic             win_s,
  output logic             out_q
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;
  logic             held_q;

  assign run_nx = run_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      run_q  <= '0;
      held_q <= 1'b0;
    end else begin
      case (mode)
        MODE_CONT:    out_q <= raw_s;
        MODE_SAMP_NF: if (tick) out_q <= raw_s;
        MODE_SAMP_FILT: begin
          if (tick) begin
            if (raw_s != out_q) begin
              if (run_nx >= cnt) begin
                out_q <= raw_s;
                run_q <= '0;
              end else begin
                run_q <= run_nx;
              end
            end else begin
              run_q <= '0;
            end
          end
        end
        MODE_WIN: if (win_s) out_q <= raw_s;
        MODE_WIN_RESAMP: begin
          if (win_s) held_q <= raw_s;
          if (tick)  out_q  <= held_q;
        end
        default: ;
      endcase
      if (clear) run_q <= '0;
    end
  end
endmodule

// File: rtl/cmpflt_top.sv
module cmpflt_top
  import cmpflt_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int PER_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic             strobe_in,
  input  logic             window_in,
  input  logic             cfg_en,
  input  logic             cfg_win_en,
  input  logic             cfg_ext_sel,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [PER_W-1:0] cfg_period,
  output logic             filt_out
);
  localparam int CFG_W = 3 + CNT_W + PER_W;

  logic [2:0]       sync_q;
  logic             raw_s;
  logic             strobe_s;
  logic             win_s;
  logic             tick;
  logic             clear;
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  mode_e            mode;

  cmpflt_sync #(.W(3), .STAGES(SYNC_STGS)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({window_in, strobe_in, raw_in}),
    .q   (sync_q)
  );

  assign raw_s    = sync_q[0];
  assign strobe_s = sync_q[1];
  assign win_s    = sync_q[2];

  assign cfg_now = {cfg_en, cfg_win_en, cfg_ext_sel, cfg_cnt, cfg_period};

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  assign clear = (cfg_now != cfg_q);

  always_comb begin
    if (!cfg_en)
      mode = MODE_OFF;
    else if (cfg_win_en)
      mode = (cfg_ext_sel || cfg_period == '0) ? MODE_WIN : MODE_WIN_RESAMP;
    else if (cfg_cnt == '0 || (!cfg_ext_sel && cfg_period == '0))
      mode = MODE_CONT;
    else if (cfg_cnt == CNT_W'(1))
      mode = MODE_SAMP_NF;
    else
      mode = MODE_SAMP_FILT;
  end

  cmpflt_tick #(.PER_W(PER_W)) tick_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .ext_sel  (cfg_ext_sel),
    .period   (cfg_period),
    .strobe_s (strobe_s),
    .tick     (tick)
  );

  cmpflt_core #(.CNT_W(CNT_W)) core_i (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .mode  (mode),
    .cnt   (cfg_cnt),
    .tick  (tick),
    .raw_s (raw_s),
    .win_s (win_s),
    .out_q (filt_out)
  );
endmodule

// File: rtl/cmpflt_chk.sv
module cmpflt_chk #(
  parameter int CNT_W = 3,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_win_en,
  input logic             cfg_ext_sel,
  input logic [CNT_W-1:0] cfg_cnt,
  input logic [PER_W-1:0] cfg_period,
  input logic             raw_s,
  input logic             win_s,
  input logic             tick,
  input logic             filt_out
);
  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !filt_out);

  assert_off_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(filt_out));

  assert_cont_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_win_en && cfg_cnt == '0) |=> (filt_out == $past(raw_s)));

  assert_sample_only_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_win_en && cfg_cnt != '0 && (cfg_ext_sel || cfg_period != '0) && !tick)
    |=> $stable(filt_out));

  assert_win_closed_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_win_en && (cfg_ext_sel || cfg_period == '0) && !win_s)
    |=> $stable(filt_out));
endmodule

bind cmpflt_top cmpflt_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_en      (cfg_en),
  .cfg_win_en  (cfg_win_en),
  .cfg_ext_sel (cfg_ext_sel),
  .cfg_cnt     (cfg_cnt),
  .cfg_period  (cfg_period),
  .raw_s       (raw_s),
  .win_s       (win_s),
  .tick        (tick),
  .filt_out    (filt_out)
);

// File: tb/cmpflt_top_tb_top.sv
`timescale 1ns/1ps
module cmpflt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_in = 1'b0;
  logic       strobe_in = 1'b0;
  logic       window_in = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_win_en = 1'b0;
  logic       cfg_ext_sel = 1'b0;
  logic [2:0] cfg_cnt = 3'd0;
  logic [7:0] cfg_period = 8'd0;
  logic       filt_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cmpflt_top dut_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .strobe_in(strobe_in),
    .window_in(window_in), .cfg_en(cfg_en), .cfg_win_en(cfg_win_en),
    .cfg_ext_sel(cfg_ext_sel), .cfg_cnt(cfg_cnt), .cfg_period(cfg_period),
    .filt_out(filt_out)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [2:0]  cnt;
    logic [11:0] lo;
    logic [11:0] hi;
  } vec_t;

  // Internal divider: latency bounds derived from R3, R5, R6
  localparam vec_t VEC [7] = '{
    '{8'd5,   3'd0, 12'd3,    12'd3},    // R3 count 0
    '{8'd0,   3'd3, 12'd3,    12'd3},    // R3 period 0
    '{8'd4,   3'd1, 12'd3,    12'd6},    // R5
    '{8'd4,   3'd3, 12'd11,   12'd14},   // R6
    '{8'd1,   3'd7, 12'd9,    12'd9},    // R6
    '{8'd10,  3'd2, 12'd13,   12'd22},   // R6
    '{8'd255, 3'd7, 12'd1533, 12'd1787}  // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Drive raw at a negedge, count edges until filt_out equals target.
  task automatic measure(input logic target, input int limit, output int lat);
    raw_in = target;
    lat = 0;
    while (lat <= limit) begin
      @(posedge clk);
      lat++;
      #1;
      if (filt_out == target) break;
    end
    @(negedge clk);
  endtask

  task automatic pulse();
    strobe_in = 1'b1;
    cycles(3);
    strobe_in = 1'b0;
    cycles(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    int lat;
    @(negedge clk);
    raw_in = 1'b1;
    cycles(4);
    check(filt_out == 1'b0, "R1 during reset", filt_out, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(filt_out == 1'b0, "R1 after release", filt_out, 0);
    @(negedge clk);
    raw_in = 1'b0;

    // Vector table walk
    for (int i = 0; i < 7; i++) begin
      cfg_en = 1'b1; cfg_win_en = 1'b0; cfg_ext_sel = 1'b0;
      cfg_cnt = VEC[i].cnt; cfg_period = VEC[i].per;
      raw_in = filt_out;
      cycles(6);
      measure(~filt_out, int'(VEC[i].hi) + 5, lat);
      check(lat >= int'(VEC[i].lo) && lat <= int'(VEC[i].hi),
            (VEC[i].cnt <= 3'd1 || VEC[i].per == 8'd0) ?
              ((VEC[i].cnt == 3'd1) ? "R5 R4 latency" : "R3 latency") : "R6 R4 latency",
            lat, int'(VEC[i].hi));
    end

    // R2: disabled holds
    cfg_cnt = 3'd0; cfg_period = 8'd0;
    raw_in = 1'b1; cycles(6);
    cfg_en = 1'b0; raw_in = 1'b0; cycles(20);
    check(filt_out == 1'b1, "R2 disabled hold", filt_out, 1);

    // Bring output low in continuous mode
    cfg_en = 1'b1; cycles(6);
    check(filt_out == 1'b0, "R3 continuous low", filt_out, 0);

    // R8 / R5: external strobe, count 1
    cfg_ext_sel = 1'b1; cfg_cnt = 3'd1; cfg_period = 8'd3;
    cycles(3);
    raw_in = 1'b1; cycles(20);
    check(filt_out == 1'b0, "R8 no strobe edge no change", filt_out, 0);
    pulse();
    check(filt_out == 1'b1, "R5 R8 strobe sample copied", filt_out, 1);

    // R7 / R6: external strobe, count 3, noise restart
    cfg_cnt = 3'd3; cycles(3);
    raw_in = 1'b0; cycles(3);
    pulse(); pulse();
    check(filt_out == 1'b1, "R6 two of three", filt_out, 1);
    raw_in = 1'b1; cycles(3); pulse();
    raw_in = 1'b0; cycles(3); pulse(); pulse();
    check(filt_out == 1'b1, "R7 run restarted", filt_out, 1);
    pulse();
    check(filt_out == 1'b0, "R7 R6 third agreeing sample", filt_out, 0);

    // R9: plain windowed
    cfg_ext_sel = 1'b0; cfg_win_en = 1'b1; cfg_period = 8'd0; cfg_cnt = 3'd0;
    window_in = 1'b0; cycles(4);
    raw_in = 1'b1; cycles(20);
    check(filt_out == 1'b0, "R9 window closed hold", filt_out, 0);
    window_in = 1'b1;
    lat = 0;
    while (lat <= 8) begin
      @(posedge clk); lat++; #1;
      if (filt_out == 1'b1) break;
    end
    @(negedge clk);
    check(lat == 3, "R9 window open latency", lat, 3);
    measure(1'b0, 8, lat);
    check(lat == 3, "R9 follow latency", lat, 3);
    window_in = 1'b0; cycles(4);
    raw_in = 1'b1; cycles(20);
    check(filt_out == 1'b0, "R9 hold after close", filt_out, 0);

    // R10: windowed resampled
    cfg_period = 8'd8; window_in = 1'b1; raw_in = 1'b0; cycles(30);
    measure(1'b1, 20, lat);
    check(lat <= 11, "R10 resample latency", lat, 11);
    window_in = 1'b0; cycles(4);
    raw_in = 1'b0; cycles(40);
    check(filt_out == 1'b1, "R10 window closed hold", filt_out, 1);

    finish_run();
  end
endmodule